// File: doc/BRIEF.md
# Multi-Bus Cascaded Grant Arbiter

This block decides, once per clock, which function units may drive each of several shared result buses. Every function unit raises one bit of a unary request vector when it has a result to move. The arbiter hands out up to one grant per bus in the same cycle, so several units can finish together instead of queuing behind a single bus.

The arbiter is a chain of picker stages, one stage per bus. Each stage is a priority encoder followed directly by a decoder, which turns the remaining requests into a one-hot grant. A stage removes the unit it granted from the request vector before passing the vector to the next stage. Lower unit index means higher priority. Bus 0 gets the best remaining requester, bus 1 the next best, and so on. A bus whose stage finds no request left stays idle.

Grants, valid flags and the binary index of each granted unit are registered. They appear one clock after the request vector is sampled.

Top module: `cbus_grant_arb`

## Requirements
- R1: While `rst_n` is low at a rising edge, all grant, valid and index outputs are zero after that edge.
- R2: Outputs reflect the request vector sampled at the previous rising edge. They change only at rising edges.
- R3: Bus 0 is granted to the requesting unit with the lowest index.
- R4: Bus b (b > 0) is granted to the lowest-indexed requesting unit not granted to any of buses 0 to b-1. Equivalently, it goes to the (b+1)-th set request bit counting up from bit 0.
- R5: Each bus grant vector is one-hot or all zero. The bus valid bit is 1 exactly when its grant vector is non-zero.
- R6: No function unit is granted more than one bus in the same cycle.
- R7: A grant is given only to a unit whose request bit was set.
- R8: The number of valid buses equals the lesser of the number of set request bits and the bus count `NUM_BUS`.
- R9: Valid buses are contiguous from bus 0: if bus b is valid, every bus below b is valid.
- R10: The index output of a valid bus holds the bit position of its grant. The index of an idle bus is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_FU | Unary request vector, bit u set when function unit u wants a bus |
| bus_gnt_o | output | NUM_BUS*NUM_FU | One-hot grant per bus; bus b occupies bits [b*NUM_FU +: NUM_FU] |
| bus_vld_o | output | NUM_BUS | Bit b set when bus b carries a grant this cycle |
| bus_idx_o | output | NUM_BUS*IDX_W | Binary index of the granted unit per bus; bus b at [b*IDX_W +: IDX_W] |

## Verification
A fault in the masking between stages shows up at the ports in the cycle right after the request. It appears either as the same unit granted to two buses or as a skipped requester that leaves the valid count below expectation. A wrong encoder tree node points the index output or the one-hot grant at the wrong unit for request patterns that reach that node, so stimulus mixes sparse, dense and single-bit patterns. These patterns place the winning bit in every subtree. Since no state lives beyond one register stage, every mismatch is visible one clock after the request that causes it.

// File: rtl/cbus_arb_pkg.sv
// Package: cbus_arb_pkg
// Shared helpers for the cascaded bus grant arbiter.
// Assumes: widths are positive; an index width of at least one bit is used
// even when only one function unit exists.
package cbus_arb_pkg;

    // Width of a binary index able to address n items (minimum one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cbus_prio_enc.sv
// Module: cbus_prio_enc
// Priority encoder built as a balanced binary tree of select nodes.
// Lowest set bit of req_i wins; found_o says whether any bit was set.
// Assumes: WIDTH >= 1; the vector is padded with zeros to a power of two,
// so depth grows with log2(WIDTH).
module cbus_prio_enc #(
    parameter int WIDTH = 8,
    parameter int IDX_W = cbus_arb_pkg::idx_width(WIDTH)
) (
    input  logic [WIDTH-1:0] req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             found_o
);
    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES;

    // Heap-ordered nodes: 1 is the root, leaves sit at LEAVES..NODES-1.
    logic [NODES-1:0] node_vld;
    logic [IDX_W-1:0] node_idx [NODES];

    // Unused slot 0 tied off so every element has a driver.
    assign node_vld[0] = 1'b0;
    assign node_idx[0] = '0;

    genvar k;
    generate
        for (k = 0; k < LEAVES; k++) begin : g_leaf
            // Leaf: carries its own request bit and fixed position.
            if (k < WIDTH) begin : g_real
                assign node_vld[LEAVES + k] = req_i[k];
            end else begin : g_pad
                assign node_vld[LEAVES + k] = 1'b0;
            end
            assign node_idx[LEAVES + k] = IDX_W'(k);
        end
        for (k = 1; k < LEAVES; k++) begin : g_node
            // Inner node: left child (lower indices) wins when valid.
            assign node_vld[k] = node_vld[2*k] | node_vld[2*k+1];
            assign node_idx[k] = node_vld[2*k] ? node_idx[2*k] : node_idx[2*k+1];
        end
    endgenerate

    // Root feeds the outputs; index forced to zero when nothing is found.
    assign found_o = node_vld[1];
    assign idx_o   = node_vld[1] ? node_idx[1] : '0;

endmodule

// File: rtl/cbus_onehot_dec.sv
// Module: cbus_onehot_dec
// Binary to one-hot decoder with enable. Output is zero when en_i is low
// or when idx_i addresses a position beyond WIDTH.
// Assumes: IDX_W is wide enough to address WIDTH positions.
module cbus_onehot_dec #(
    parameter int WIDTH = 8,
    parameter int IDX_W = cbus_arb_pkg::idx_width(WIDTH)
) (
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [WIDTH-1:0] onehot_o
);
    genvar u;
    generate
        for (u = 0; u < WIDTH; u++) begin : g_bit
            // One comparator per output position.
            assign onehot_o[u] = en_i && (idx_i == IDX_W'(u));
        end
    endgenerate

endmodule

// File: rtl/cbus_pick_stage.sv
// Module: cbus_pick_stage
// One link of the grant chain: encoder and decoder back to back pick the
// best remaining requester, then that unit is cleared from the vector
// handed to the next link.
// Assumes: avail_i already excludes units granted by earlier links.
module cbus_pick_stage #(
    parameter int NUM_FU = 8,
    parameter int IDX_W  = cbus_arb_pkg::idx_width(NUM_FU)
) (
    input  logic [NUM_FU-1:0] avail_i,
    output logic [NUM_FU-1:0] gnt_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              vld_o,
    output logic [NUM_FU-1:0] avail_o
);
    logic [IDX_W-1:0] win_idx;
    logic             win_found;

    cbus_prio_enc #(
        .WIDTH (NUM_FU),
        .IDX_W (IDX_W)
    ) enc_i (
        .req_i   (avail_i),
        .idx_o   (win_idx),
        .found_o (win_found)
    );

    cbus_onehot_dec #(
        .WIDTH (NUM_FU),
        .IDX_W (IDX_W)
    ) dec_i (
        .en_i     (win_found),
        .idx_i    (win_idx),
        .onehot_o (gnt_o)
    );

    // Results of this link and the masked vector for the next one.
    assign idx_o   = win_idx;
    assign vld_o   = win_found;
    assign avail_o = avail_i & ~gnt_o;

endmodule

// File: rtl/cbus_grant_arb.sv
// Module: cbus_grant_arb
// Grants up to NUM_BUS function units a result bus each per cycle with a
// chain of picker stages; stage b serves bus b. Lower unit index has
// higher priority. All outputs are registered.
// Assumes: synchronous active-low reset; req_i is stable around the edge.
module cbus_grant_arb #(
    parameter int NUM_FU  = 8,
    parameter int NUM_BUS = 3,
    parameter int IDX_W   = cbus_arb_pkg::idx_width(NUM_FU)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_FU-1:0]          req_i,
    output logic [NUM_BUS*NUM_FU-1:0]  bus_gnt_o,
    output logic [NUM_BUS-1:0]         bus_vld_o,
    output logic [NUM_BUS*IDX_W-1:0]   bus_idx_o
);
    localparam int GNT_W = NUM_BUS * NUM_FU;
    localparam int IDXV_W = NUM_BUS * IDX_W;

    // Vector entering each stage; entry NUM_BUS is what is left over.
    logic [NUM_FU-1:0]  avail [NUM_BUS+1];
    logic [GNT_W-1:0]   gnt_nxt;
    logic [NUM_BUS-1:0] vld_nxt;
    logic [IDXV_W-1:0]  idx_nxt;

    assign avail[0] = req_i;

    genvar b;
    generate
        for (b = 0; b < NUM_BUS; b++) begin : g_stage
            cbus_pick_stage #(
                .NUM_FU (NUM_FU),
                .IDX_W  (IDX_W)
            ) stage_i (
                .avail_i (avail[b]),
                .gnt_o   (gnt_nxt[b*NUM_FU +: NUM_FU]),
                .idx_o   (idx_nxt[b*IDX_W +: IDX_W]),
                .vld_o   (vld_nxt[b]),
                .avail_o (avail[b+1])
            );
        end
    endgenerate

    // Output register: clear on reset, otherwise capture this cycle's picks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_gnt_o <= '0;
            bus_vld_o <= '0;
            bus_idx_o <= '0;
        end else begin
            bus_gnt_o <= gnt_nxt;
            bus_vld_o <= vld_nxt;
            bus_idx_o <= idx_nxt;
        end
    end

endmodule

// File: rtl/cbus_grant_arb_chk.sv
// Module: cbus_grant_arb_chk
// Property checker for cbus_grant_arb, attached through bind. Relates the
// registered outputs to the request vector of the previous cycle.
// Assumes: bench holds rst_n low from time zero.
module cbus_grant_arb_chk #(
    parameter int NUM_FU  = 8,
    parameter int NUM_BUS = 3,
    parameter int IDX_W   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_FU-1:0]         req_i,
    input logic [NUM_BUS*NUM_FU-1:0] bus_gnt_o,
    input logic [NUM_BUS-1:0]        bus_vld_o,
    input logic [NUM_BUS*IDX_W-1:0]  bus_idx_o
);
    logic [NUM_FU-1:0] gnt_union;

    // Union of all bus grants.
    always_comb begin
        gnt_union = '0;
        for (int b = 0; b < NUM_BUS; b++) begin
            gnt_union = gnt_union | bus_gnt_o[b*NUM_FU +: NUM_FU];
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (bus_vld_o == '0 && bus_gnt_o == '0 && bus_idx_o == '0));

    p_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bus_gnt_o) == $countones(gnt_union));

    p_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((gnt_union & ~$past(req_i)) == '0));

    p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(bus_vld_o) ==
            (($countones($past(req_i)) < NUM_BUS) ? $countones($past(req_i)) : NUM_BUS)));

    genvar b;
    generate
        for (b = 0; b < NUM_BUS; b++) begin : g_bus
            p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(bus_gnt_o[b*NUM_FU +: NUM_FU]) &&
                (bus_vld_o[b] == (bus_gnt_o[b*NUM_FU +: NUM_FU] != '0)));

            p_idx_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
                bus_vld_o[b] ? bus_gnt_o[b*NUM_FU + int'(bus_idx_o[b*IDX_W +: IDX_W])]
                             : (bus_idx_o[b*IDX_W +: IDX_W] == '0));

            if (b > 0) begin : g_upper
                p_contig_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    bus_vld_o[b] |-> bus_vld_o[b-1]);
            end
        end
    endgenerate

endmodule

bind cbus_grant_arb cbus_grant_arb_chk #(
    .NUM_FU  (NUM_FU),
    .NUM_BUS (NUM_BUS),
    .IDX_W   (IDX_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .bus_gnt_o (bus_gnt_o),
    .bus_vld_o (bus_vld_o),
    .bus_idx_o (bus_idx_o)
);

// File: tb/cbus_grant_arb_tb_top.sv
`timescale 1ns/1ps
module cbus_grant_arb_tb_top;
    localparam int NFU  = 8;
    localparam int NBUS = 3;
    localparam int IW   = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NFU-1:0]       req = '0;
    logic [NBUS*NFU-1:0]  gnt;
    logic [NBUS-1:0]      vld;
    logic [NBUS*IW-1:0]   idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cbus_grant_arb #(.NUM_FU(NFU), .NUM_BUS(NBUS)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .bus_gnt_o (gnt),
        .bus_vld_o (vld),
        .bus_idx_o (idx)
    );

    // Expected grants: k-th set bit from the bottom goes to bus k (R3, R4).
    function automatic logic [NBUS*NFU-1:0] exp_gnt(input logic [NFU-1:0] r);
        logic [NBUS*NFU-1:0] g = '0;
        int b = 0;
        for (int u = 0; u < NFU; u++) begin
            if (r[u] && b < NBUS) begin
                g[b*NFU + u] = 1'b1;
                b++;
            end
        end
        return g;
    endfunction

    function automatic logic [NBUS*IW-1:0] exp_idx(input logic [NFU-1:0] r);
        logic [NBUS*IW-1:0] x = '0;
        int b = 0;
        for (int u = 0; u < NFU; u++) begin
            if (r[u] && b < NBUS) begin
                x[b*IW +: IW] = IW'(u);
                b++;
            end
        end
        return x;
    endfunction

    function automatic logic [NBUS-1:0] exp_vld(input logic [NFU-1:0] r);
        int n = $countones(r);
        logic [NBUS-1:0] v = '0;
        for (int b = 0; b < NBUS; b++) v[b] = (b < n);
        return v;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drive one request, wait one edge (R2), compare all outputs.
    task automatic apply(input logic [NFU-1:0] r, input string tag);
        logic [NBUS*NFU-1:0] eg;
        logic [NFU-1:0] uni;
        req = r;
        @(posedge clk);
        @(negedge clk);
        eg = exp_gnt(r);
        check({tag, " R3/R4 grant"}, 64'(gnt), 64'(eg));
        check({tag, " R9 valid"}, 64'(vld), 64'(exp_vld(r)));
        check({tag, " R10 index"}, 64'(idx), 64'(exp_idx(r)));
        uni = '0;
        for (int b = 0; b < NBUS; b++) uni = uni | gnt[b*NFU +: NFU];
        check({tag, " R6 disjoint"}, 64'($countones(gnt)), 64'($countones(uni)));
        check({tag, " R7 subset"}, 64'(uni & ~r), 64'(0));
        check({tag, " R8 count"}, 64'($countones(vld)),
              64'(($countones(r) < NBUS) ? $countones(r) : NBUS));
        for (int b = 0; b < NBUS; b++)
            check({tag, " R5 onehot"}, 64'($onehot0(gnt[b*NFU +: NFU]) &&
                  (vld[b] == (gnt[b*NFU +: NFU] != '0))), 64'(1));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20517));
        req = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears outputs even with all requests raised.
        check("R1 reset grant", 64'(gnt), 64'(0));
        check("R1 reset valid", 64'(vld), 64'(0));
        check("R1 reset index", 64'(idx), 64'(0));
        rst_n = 1'b1;
        // R2: outputs hold previous value until the edge.
        req = 8'h10;
        #1;
        check("R2 no change before edge", 64'(vld), 64'(0));
        @(posedge clk);
        @(negedge clk);
        check("R2 registered", 64'(gnt), 64'(exp_gnt(8'h10)));
        apply(8'h00, "none");
        apply(8'hFF, "all");
        apply(8'h80, "top only");
        apply(8'h01, "bottom only R3");
        apply(8'h92, "three");
        apply(8'h24, "two");
        apply(8'hF0, "upper four");
        apply(8'h81, "ends");
        for (int i = 0; i < 600; i++) begin
            logic [NFU-1:0] r;
            case (i % 3)
                0: r = NFU'($urandom);
                1: r = NFU'($urandom & $urandom & $urandom);
                default: r = NFU'($urandom | $urandom);
            endcase
            apply(r, "random");
        end
        // R1: reset mid-run clears again.
        req = 8'h0F;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset mid-run", 64'(vld), 64'(0));
        rst_n = 1'b1;
        apply(8'h0F, "after reset");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule